// File: doc/BRIEF.md
# USB Transfer Descriptor Status Updater

This block rewrites the status fields of one USB transfer descriptor after each transaction attempt. The descriptor's current status (Active, a 2-bit retry countdown, the completion-interrupt request, the short-packet-detect request, Stalled and the CRC/time-out bit) is presented together with the outcome of the attempt, the received byte count, the endpoint's maximum packet size, the transfer direction and the transfer type. On the next clock edge the block presents the rewritten status and a set of one-cycle event pulses. The surrounding engine then writes the status back and raises its interrupt flags from those pulses.

Errors consume the retry countdown. When the countdown runs out, the descriptor is stalled and marked as failed through a CRC/time-out flag. A countdown loaded as zero means the descriptor retries without limit. A successful attempt retires the descriptor. When an inbound data packet on a control, bulk or interrupt transfer is shorter than the maximum packet size, the whole multi-descriptor transfer ends, even if later descriptors of that transfer are still active.

The block also contains a response watchdog that counts full-speed bit times from the end of a transmitted packet. If no start-of-packet is seen within the limit, it raises a pending time-out, and the next update treats that time-out as an error.

Top module: `td_status_updater`

## Requirements
- R1: After reset, out_valid, rsp_timeout, all status outputs and all event pulses are 0. The result of an update with upd_valid high appears on the clock edge that samples it: out_valid is high for exactly that one cycle, and the status outputs hold their values until the next update.
- R2: When an Active descriptor's attempt succeeds (outcome 0 and no pending time-out), out_active is 0, the countdown is unchanged, Stalled and CRC/time-out pass through, and ev_done pulses.
- R3: An error is outcome 1 (CRC), outcome 2 or 3 (time-out), or a pending response time-out. An error on an Active descriptor whose countdown is 2 or 3 decrements the countdown by one, keeps Active at 1, and raises no event pulse.
- R4: An error on an Active descriptor whose countdown is 1 sets the countdown to 0, clears Active, sets Stalled and CRC/time-out, and pulses ev_err_done but not ev_done.
- R5: An error on an Active descriptor whose countdown is 0 leaves the countdown at 0 and Active at 1, and raises no pulse.
- R6: A successful attempt with dir_in=1, xfer_type 0 (control), 2 (bulk) or 3 (interrupt), and rx_len < max_pkt pulses ev_set_end. Type 1 (isochronous), dir_in=0, or rx_len >= max_pkt never pulse it.
- R7: ev_short pulses only together with ev_set_end and only when the descriptor's short-packet-detect bit (in_spd) is 1.
- R8: A descriptor with in_active=0 is passed through with every status field unchanged, and no event pulse is raised.
- R9: rsp_timeout rises on the TMO_BITS-th bit_tick (19 by default) counted after eop_seen, unless sop_seen arrives first. It is cleared by an update or by a new eop_seen.
- R10: out_ioc and out_spd always equal the in_ioc and in_spd of the sampled update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per full-speed bit time |
| eop_seen | input | 1 | End of a transmitted packet; starts the response watchdog |
| sop_seen | input | 1 | Start of the device response; stops the watchdog |
| upd_valid | input | 1 | Apply an update with the inputs below |
| in_active | input | 1 | Descriptor Active bit |
| in_err_cnt | input | 2 | Retry countdown (0 = unlimited) |
| in_ioc | input | 1 | Completion-interrupt request bit |
| in_spd | input | 1 | Short-packet-detect bit |
| in_stalled | input | 1 | Stalled bit |
| in_crc_to | input | 1 | CRC/time-out status bit |
| outcome | input | 2 | 0 success, 1 CRC error, 2/3 time-out |
| dir_in | input | 1 | 1 when the data phase is device-to-host |
| xfer_type | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| rx_len | input | LEN_W | Received byte count |
| max_pkt | input | LEN_W | Endpoint maximum packet size |
| out_valid | output | 1 | Result valid for one cycle |
| out_active | output | 1 | Rewritten Active bit |
| out_err_cnt | output | 2 | Rewritten countdown |
| out_ioc | output | 1 | Completion-interrupt request, passed through |
| out_spd | output | 1 | Short-packet-detect, passed through |
| out_stalled | output | 1 | Rewritten Stalled bit |
| out_crc_to | output | 1 | Rewritten CRC/time-out bit |
| ev_done | output | 1 | Successful completion pulse |
| ev_err_done | output | 1 | Completion by error exhaustion pulse |
| ev_set_end | output | 1 | Short packet ended the transfer set |
| ev_short | output | 1 | Short-packet event for a descriptor that requests it |
| rsp_timeout | output | 1 | Response time-out pending |

## Verification
The assertions check the following on every cycle: the single-cycle result strobe, the mutual exclusion of the two completion pulses, the stall state that must come with an error completion, the gating of the short-packet pulse, the pass-through of inactive descriptors, the unlimited-retry case, and that the watchdog only fires on a bit tick. The exact countdown arithmetic, the short-packet length comparison across transfer types and directions, and the watchdog's tick count and its cancellation by a response can only be shown by the bench's scenarios. The bench compares those results against a model of the requirements.

// File: rtl/td_pkg.sv
package td_pkg;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_CRC  = 2'd1,
    RES_TMO  = 2'd2,
    RES_TMO2 = 2'd3
  } td_result_e;

  typedef enum logic [1:0] {
    XT_CTRL = 2'd0,
    XT_ISO  = 2'd1,
    XT_BULK = 2'd2,
    XT_INTR = 2'd3
  } td_xfer_e;

  localparam int CNT_W = 2;

  typedef struct packed {
    logic             active;
    logic [CNT_W-1:0] err_cnt;
    logic             ioc;
    logic             spd;
    logic             stalled;
    logic             crc_to;
  } td_stat_t;

  typedef struct packed {
    logic done;
    logic err_done;
    logic set_end;
    logic short_pkt;
  } td_evt_t;

endpackage

// File: rtl/td_rsp_timer.sv
module td_rsp_timer #(
  parameter int TMO_BITS = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic eop_seen,
  input  logic sop_seen,
  input  logic consume,
  output logic expired
);
  localparam int CW = $clog2(TMO_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_BITS - 1);

  logic          waiting_q, waiting_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  // next state
  always_comb begin
    waiting_d = waiting_q;
    cnt_d     = cnt_q;
    exp_d     = exp_q;
    if (consume) exp_d = 1'b0;
    if (eop_seen) begin
      waiting_d = 1'b1;
      cnt_d     = '0;
      exp_d     = 1'b0;
    end else if (sop_seen) begin
      waiting_d = 1'b0;
      cnt_d     = '0;
    end else if (waiting_q && bit_tick) begin
      if (cnt_q == LAST) begin
        waiting_d = 1'b0;
        cnt_d     = '0;
        exp_d     = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      cnt_q     <= '0;
      exp_q     <= 1'b0;
    end else begin
      waiting_q <= waiting_d;
      cnt_q     <= cnt_d;
      exp_q     <= exp_d;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/td_status_next.sv
module td_status_next
  import td_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  td_stat_t         cur,
  input  logic [1:0]       outcome,
  input  logic             tmo_pending,
  input  logic             dir_in,
  input  logic [1:0]       xfer_type,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] max_pkt,
  output td_stat_t         nxt,
  output td_evt_t          evt
);
  logic is_err;
  logic short_hit;
  logic short_type;

  assign is_err     = (outcome != RES_OK) || tmo_pending;
  assign short_type = (xfer_type != XT_ISO);
  assign short_hit  = dir_in && short_type && (rx_len < max_pkt);

  always_comb begin
    nxt = cur;
    evt = '0;
    if (cur.active) begin
      if (is_err) begin
        if (cur.err_cnt == CNT_W'(1)) begin
          nxt.err_cnt  = '0;
          nxt.active   = 1'b0;
          nxt.stalled  = 1'b1;
          nxt.crc_to   = 1'b1;
          evt.err_done = 1'b1;
        end else if (cur.err_cnt != '0) begin
          nxt.err_cnt = cur.err_cnt - 1'b1;
        end
      end else begin
        nxt.active    = 1'b0;
        evt.done      = 1'b1;
        evt.set_end   = short_hit;
        evt.short_pkt = short_hit && cur.spd;
      end
    end
  end
endmodule

// File: rtl/td_status_reg.sv
module td_status_reg
  import td_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  td_stat_t nxt,
  input  td_evt_t  evt,
  output logic     vld,
  output td_stat_t stat,
  output td_evt_t  pulses
);
  td_stat_t stat_q, stat_d;
  td_evt_t  evt_q, evt_d;
  logic     vld_q, vld_d;

  always_comb begin
    stat_d = load ? nxt : stat_q;
    evt_d  = load ? evt : '0;
    vld_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      evt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      evt_q  <= evt_d;
      vld_q  <= vld_d;
    end
  end

  assign stat   = stat_q;
  assign pulses = evt_q;
  assign vld    = vld_q;
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int TMO_BITS = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             eop_seen,
  input  logic             sop_seen,
  input  logic             upd_valid,
  input  logic             in_active,
  input  logic [1:0]       in_err_cnt,
  input  logic             in_ioc,
  input  logic             in_spd,
  input  logic             in_stalled,
  input  logic             in_crc_to,
  input  logic [1:0]       outcome,
  input  logic             dir_in,
  input  logic [1:0]       xfer_type,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] max_pkt,
  output logic             out_valid,
  output logic             out_active,
  output logic [1:0]       out_err_cnt,
  output logic             out_ioc,
  output logic             out_spd,
  output logic             out_stalled,
  output logic             out_crc_to,
  output logic             ev_done,
  output logic             ev_err_done,
  output logic             ev_set_end,
  output logic             ev_short,
  output logic             rsp_timeout
);
  td_stat_t cur, nxt, stat;
  td_evt_t  evt, pulses;
  logic     tmo_pending;

  assign cur = '{active: in_active, err_cnt: in_err_cnt, ioc: in_ioc,
                 spd: in_spd, stalled: in_stalled, crc_to: in_crc_to};

  td_rsp_timer #(.TMO_BITS(TMO_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .eop_seen (eop_seen),
    .sop_seen (sop_seen),
    .consume  (upd_valid),
    .expired  (tmo_pending)
  );

  td_status_next #(.LEN_W(LEN_W)) u_next (
    .cur         (cur),
    .outcome     (outcome),
    .tmo_pending (tmo_pending),
    .dir_in      (dir_in),
    .xfer_type   (xfer_type),
    .rx_len      (rx_len),
    .max_pkt     (max_pkt),
    .nxt         (nxt),
    .evt         (evt)
  );

  td_status_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (upd_valid),
    .nxt    (nxt),
    .evt    (evt),
    .vld    (out_valid),
    .stat   (stat),
    .pulses (pulses)
  );

  assign out_active  = stat.active;
  assign out_err_cnt = stat.err_cnt;
  assign out_ioc     = stat.ioc;
  assign out_spd     = stat.spd;
  assign out_stalled = stat.stalled;
  assign out_crc_to  = stat.crc_to;
  assign ev_done     = pulses.done;
  assign ev_err_done = pulses.err_done;
  assign ev_set_end  = pulses.set_end;
  assign ev_short    = pulses.short_pkt;
  assign rsp_timeout = tmo_pending;
endmodule

// File: rtl/td_status_updater_chk.sv
module td_status_updater_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             upd_valid,
  input logic             in_active,
  input logic [1:0]       in_err_cnt,
  input logic             in_ioc,
  input logic             in_spd,
  input logic             out_valid,
  input logic             out_active,
  input logic [1:0]       out_err_cnt,
  input logic             out_ioc,
  input logic             out_spd,
  input logic             out_stalled,
  input logic             out_crc_to,
  input logic             ev_done,
  input logic             ev_err_done,
  input logic             ev_set_end,
  input logic             ev_short,
  input logic             rsp_timeout
);
  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> out_valid);

  // R1
  no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(ev_done || ev_err_done || ev_set_end || ev_short));

  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_err_done}));

  // R4
  stall_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_done |-> (!out_active && out_stalled && out_crc_to && out_err_cnt == 2'd0));

  // R7
  short_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short |-> (ev_set_end && ev_done && out_spd));

  // R8
  inactive_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !in_active) |=>
      (!out_active && !ev_done && !ev_err_done && !ev_set_end && out_err_cnt == $past(in_err_cnt)));

  // R5
  unlimited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && in_active && in_err_cnt == 2'd0) |=> (!ev_err_done && out_err_cnt == 2'd0));

  // R10
  flags_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (out_ioc == $past(in_ioc) && out_spd == $past(in_spd)));

  // R9
  tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_timeout) |-> $past(bit_tick));
endmodule

bind td_status_updater td_status_updater_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/td_status_updater_test.sv
`timescale 1ns/1ps
module td_status_updater_test;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, eop_seen = 0, sop_seen = 0, upd_valid = 0;
  logic in_active = 0, in_ioc = 0, in_spd = 0, in_stalled = 0, in_crc_to = 0;
  logic [1:0] in_err_cnt = 0, outcome = 0, xfer_type = 0;
  logic dir_in = 0;
  logic [LEN_W-1:0] rx_len = 0, max_pkt = 0;
  logic out_valid, out_active, out_ioc, out_spd, out_stalled, out_crc_to;
  logic [1:0] out_err_cnt;
  logic ev_done, ev_err_done, ev_set_end, ev_short, rsp_timeout;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  td_status_updater #(.LEN_W(LEN_W), .TMO_BITS(19)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model: {active, cnt[1:0], ioc, spd, stalled, crc_to, done, err_done, set_end, short}
  function automatic logic [10:0] model(input logic a, input logic [1:0] c, input logic i,
      input logic s, input logic st, input logic ct, input logic err, input logic din,
      input logic [1:0] xt, input logic [LEN_W-1:0] rl, input logic [LEN_W-1:0] mp);
    logic a2 = a; logic [1:0] c2 = c; logic st2 = st; logic ct2 = ct;
    logic d = 0, ed = 0, se = 0, sh = 0;
    if (a) begin
      if (err) begin
        if (c == 2'd1) begin c2 = 0; a2 = 0; st2 = 1; ct2 = 1; ed = 1; end
        else if (c != 0) c2 = c - 2'd1;
      end else begin
        a2 = 0; d = 1;
        se = din && (xt != 2'd1) && (rl < mp);
        sh = se && s;
      end
    end
    return {a2, c2, i, s, st2, ct2, d, ed, se, sh};
  endfunction

  function automatic logic [10:0] observed();
    return {out_active, out_err_cnt, out_ioc, out_spd, out_stalled, out_crc_to,
            ev_done, ev_err_done, ev_set_end, ev_short};
  endfunction

  task automatic do_upd(input string req, input logic a, input logic [1:0] c, input logic i,
      input logic s, input logic st, input logic ct, input logic [1:0] oc, input logic tmo,
      input logic din, input logic [1:0] xt, input logic [LEN_W-1:0] rl, input logic [LEN_W-1:0] mp);
    logic [10:0] exp;
    @(negedge clk);
    in_active = a; in_err_cnt = c; in_ioc = i; in_spd = s; in_stalled = st; in_crc_to = ct;
    outcome = oc; dir_in = din; xfer_type = xt; rx_len = rl; max_pkt = mp; upd_valid = 1;
    exp = model(a, c, i, s, st, ct, (oc != 0) || tmo, din, xt, rl, mp);
    @(negedge clk);
    upd_valid = 0;
    check({req, " R1 valid"}, 32'(out_valid), 32'd1);
    check(req, 32'(observed()), 32'(exp));
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", 32'({out_valid, observed(), rsp_timeout}), 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R2 plain success
    do_upd("R2 success", 1, 2'd3, 1, 0, 0, 0, 2'd0, 0, 0, 2'd2, 11'd0, 11'd64);
    @(negedge clk);
    check("R1 hold", 32'({out_valid, out_err_cnt, ev_done}), 32'({1'b0, 2'd3, 1'b0}));
    // R3 decrement
    do_upd("R3 crc dec", 1, 2'd3, 0, 0, 0, 0, 2'd1, 0, 1, 2'd2, 11'd5, 11'd64);
    do_upd("R3 tmo dec", 1, 2'd2, 0, 0, 0, 0, 2'd2, 0, 0, 2'd0, 11'd5, 11'd64);
    // R4 exhaustion
    do_upd("R4 stall", 1, 2'd1, 1, 1, 0, 0, 2'd3, 0, 1, 2'd3, 11'd5, 11'd64);
    // R5 unlimited
    do_upd("R5 unlimited", 1, 2'd0, 0, 0, 0, 0, 2'd1, 0, 1, 2'd2, 11'd5, 11'd64);
    // R6 short packet ends set, R7 gated by spd
    do_upd("R6 short bulk nospd", 1, 2'd3, 0, 0, 0, 0, 2'd0, 0, 1, 2'd2, 11'd10, 11'd64);
    do_upd("R7 short intr spd", 1, 2'd3, 0, 1, 0, 0, 2'd0, 0, 1, 2'd3, 11'd63, 11'd64);
    do_upd("R6 iso not short", 1, 2'd3, 0, 1, 0, 0, 2'd0, 0, 1, 2'd1, 11'd10, 11'd64);
    do_upd("R6 out not short", 1, 2'd3, 0, 1, 0, 0, 2'd0, 0, 0, 2'd0, 11'd10, 11'd64);
    do_upd("R6 equal not short", 1, 2'd3, 0, 1, 0, 0, 2'd0, 0, 1, 2'd0, 11'd64, 11'd64);
    // R8 inactive pass-through
    do_upd("R8 inactive", 0, 2'd1, 1, 1, 1, 1, 2'd1, 0, 1, 2'd2, 11'd1, 11'd64);
    // R9 watchdog
    @(negedge clk); eop_seen = 1; @(negedge clk); eop_seen = 0;
    tick_n(18);
    check("R9 before limit", 32'(rsp_timeout), 32'd0);
    tick_n(1);
    check("R9 at limit", 32'(rsp_timeout), 32'd1);
    do_upd("R9 pending counts as error", 1, 2'd3, 0, 0, 0, 0, 2'd0, 1, 1, 2'd2, 11'd64, 11'd64);
    check("R9 cleared by update", 32'(rsp_timeout), 32'd0);
    @(negedge clk); eop_seen = 1; @(negedge clk); eop_seen = 0;
    tick_n(10);
    @(negedge clk); sop_seen = 1; @(negedge clk); sop_seen = 0;
    tick_n(25);
    check("R9 cancelled by sop", 32'(rsp_timeout), 32'd0);
    do_upd("R9 no pending after sop", 1, 2'd3, 0, 0, 0, 0, 2'd0, 0, 0, 2'd2, 11'd64, 11'd64);
    // random mix: R2 R3 R4 R5 R6 R7 R8 R10
    for (int n = 0; n < 300; n++) begin
      logic [LEN_W-1:0] mp = 11'($urandom_range(1, 64));
      logic [LEN_W-1:0] rl = 11'($urandom_range(0, 70));
      do_upd("R10 random", 1'($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0,
             0, 1'($urandom), 2'($urandom), rl, mp);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule